// File: doc/BRIEF.md
# Dual Prescaled Reference Timer

This block holds two 16-bit up-counting timers behind a small word-addressed register bus. Each timer picks a count source: the internal clock, the internal clock divided by a fixed slow factor, or a chained source that this block does not implement. The source then passes through two cascaded 8-bit prescalers. On every prescaled tick the counter is compared with a reference value. A match raises a reference event flag. The counter then either returns to zero or keeps counting, depending on a mode bit.

Both timers share one global configuration register that holds a stop control and a reset control for each timer. The usual bring-up is a fixed sequence. Hold the timer in stop and reset, then keep stop and release reset. Load the prescalers, mode, counter and reference, clear pending events, and finally release stop. Each timer drives its own interrupt line. The line is high while the reference event flag is set and the interrupt enable in its mode register is on.

Register map (word address on `bus_addr`): address 0 is the global configuration register. Timer 0 occupies addresses 8 to 12 and timer 1 occupies addresses 16 to 20. Within each timer's group, offset 0 is the mode register, 1 the primary prescaler, 2 the counter, 3 the reference and 4 the event register. All other addresses read as zero.

Top module: `gtm_pair`

## Requirements
- R1: All registers reset to zero, and reserved bits and unmapped addresses read as zero. The mode register keeps only bits [15:8], 4, 3 and [2:1], so it reads back as the written value AND 0xFF1E. The primary prescaler keeps bits [7:0]. The global register keeps bits 5, 4, 1 and 0. The event register keeps only bit 1.
- R2: Mode bits [2:1] select the count source. Value 1 means every internal clock and value 2 means one clock in 16. Values 0 and 3 produce no counting.
- R3: With a running timer, one count tick occurs every (P+1)*(S+1) source ticks. P is the primary prescaler [7:0] and S is mode bits [15:8]. In slow mode this gives 16*(P+1)*(S+1) clocks per tick.
- R4: When mode bit 3 is set, the counter loads zero on the tick where it equals the reference.
- R5: When mode bit 3 is clear, the counter increments on every tick and wraps from 0xFFFF to 0x0000. The wrap raises no event unless the reference matches.
- R6: Event bit 1 sets on the tick where the counter equals the reference. The timer's irq output is high while that bit and mode bit 4 are both set.
- R7: Writing a one to event bit 1 clears it. Writing a zero there leaves it unchanged.
- R8: In the global register, timer 0 uses bit 1 as stop and bit 0 as reset, and timer 1 uses bit 5 as stop and bit 4 as reset. Each timer's controls leave the other timer unaffected.
- R9: While a timer's reset bit is set, its counter, prescaler state and event flag are held at zero, and writes to its counter are ignored.
- R10: While a timer is stopped and not in reset, its counter and prescaler state hold. Writes to the counter and configuration registers take effect, and counting resumes from them when stop is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register, combinational |
| irq | output | 2 | Per-timer interrupt, bit t belongs to timer t |

## Verification
The bench builds the block with its default parameters: 16-bit counters, 8-bit prescalers and a slow divide of 16. With these settings an interval of a few dozen clocks, such as a primary prescale of 1 with a secondary of 2, or slow mode with a primary of 1, exercises the full cascade and the slow divider. Presetting the counter near 0xFFFF brings the 16-bit wrap within a handful of ticks. A behavioural model of both timers predicts the irq lines and the value on the read port in every cycle. Directed measurements of the interrupt latency, the stop hold and the reset clear back up the model.

// File: rtl/gtm_pkg.sv
package gtm_pkg;
  // offsets inside one timer's register group
  localparam logic [2:0] OFS_MODE = 3'd0;
  localparam logic [2:0] OFS_PSR  = 3'd1;
  localparam logic [2:0] OFS_CNT  = 3'd2;
  localparam logic [2:0] OFS_REF  = 3'd3;
  localparam logic [2:0] OFS_EVT  = 3'd4;

  // mode register field positions
  localparam int MODE_SRC_LSB = 1;
  localparam int MODE_FRR_BIT = 3;
  localparam int MODE_IE_BIT  = 4;
  localparam int MODE_SPS_LSB = 8;
  localparam int EVT_REF_BIT  = 1;

  typedef enum logic [1:0] {
    SRC_CHAIN = 2'd0,
    SRC_INT   = 2'd1,
    SRC_SLOW  = 2'd2,
    SRC_NONE  = 2'd3
  } src_e;

  // global register bit positions depend on timer parity
  function automatic int stop_pos(input int t);
    return (t % 2 == 1) ? 5 : 1;
  endfunction

  function automatic int rst_pos(input int t);
    return (t % 2 == 1) ? 4 : 0;
  endfunction
endpackage

// File: rtl/gtm_ticker.sv
module gtm_ticker
  import gtm_pkg::*;
#(
  parameter int PS_W     = 8,
  parameter int SLOW_DIV = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            stop,
  input  src_e            src,
  input  logic [PS_W-1:0] psr,
  input  logic [PS_W-1:0] sps,
  output logic            cnt_tick
);
  localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_DIV - 1);

  logic [SW-1:0]   slow_q;
  logic [PS_W-1:0] pri_q, sec_q;
  logic            run, slow_tick, src_tick, pri_wrap;

  function automatic logic [PS_W-1:0] step_mod(input logic [PS_W-1:0] cur,
                                               input logic [PS_W-1:0] lim);
    return (cur >= lim) ? '0 : cur + 1'b1;
  endfunction

  assign run       = !stop && !clr;
  assign slow_tick = run && (slow_q == SLOW_LAST);
  assign src_tick  = run && ((src == SRC_INT) || (src == SRC_SLOW && slow_tick));
  assign pri_wrap  = src_tick && (pri_q >= psr);
  assign cnt_tick  = pri_wrap && (sec_q >= sps);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      slow_q <= '0;
      pri_q  <= '0;
      sec_q  <= '0;
    end else begin
      if (run)      slow_q <= (slow_q == SLOW_LAST) ? '0 : slow_q + 1'b1;
      if (src_tick) pri_q  <= step_mod(pri_q, psr);
      if (pri_wrap) sec_q  <= step_mod(sec_q, sps);
    end
  end
endmodule

// File: rtl/gtm_count.sv
module gtm_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] ref_val,
  input  logic             we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  function automatic logic [CNT_W-1:0] next_cnt(input logic [CNT_W-1:0] cur,
                                                 input logic match,
                                                 input logic rs);
    return (match && rs) ? '0 : cur + 1'b1;
  endfunction

  assign hit = tick && (cnt == ref_val);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  cnt <= '0;
    else if (we)        cnt <= wdata;
    else if (tick)      cnt <= next_cnt(cnt, cnt == ref_val, restart);
  end
endmodule

// File: rtl/gtm_evt.sv
module gtm_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  input  logic ack,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) flag <= 1'b0;
    else               flag <= (flag && !ack) || set;
  end
endmodule

// File: rtl/gtm_pair.sv
module gtm_pair
  import gtm_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PS_W     = 8,
  parameter int SLOW_DIV = 16,
  parameter int ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [1:0]        irq
);
  localparam int NT    = 2;
  localparam int OFS_W = 3;
  localparam int GRP_W = ADDR_W - OFS_W;

  logic [GRP_W-1:0] grp;
  logic [OFS_W-1:0] ofs;
  logic             cfg_sel;

  // per-timer state, exposed as named wires for the checker
  logic [NT-1:0]            tmr_stop, tmr_rst;
  logic [NT-1:0][1:0]       src_q;
  logic [NT-1:0]            frr_q, ie_q;
  logic [NT-1:0][PS_W-1:0]  sps_q, psr_q;
  logic [NT-1:0][CNT_W-1:0] ref_q, cnt_q;
  logic [NT-1:0]            cnt_tick, ref_hit, evt_flag, cnt_we;
  logic [NT-1:0]            sel, mode_we, psr_we, ref_we, evt_we;

  assign grp     = bus_addr[ADDR_W-1:OFS_W];
  assign ofs     = bus_addr[OFS_W-1:0];
  assign cfg_sel = (grp == '0) && (ofs == '0);

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    localparam int SP = stop_pos(t);
    localparam int RP = rst_pos(t);

    assign sel[t]     = (grp == GRP_W'(t + 1));
    assign mode_we[t] = bus_we && sel[t] && (ofs == OFS_MODE);
    assign psr_we[t]  = bus_we && sel[t] && (ofs == OFS_PSR);
    assign cnt_we[t]  = bus_we && sel[t] && (ofs == OFS_CNT);
    assign ref_we[t]  = bus_we && sel[t] && (ofs == OFS_REF);
    assign evt_we[t]  = bus_we && sel[t] && (ofs == OFS_EVT);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tmr_stop[t] <= 1'b0;
        tmr_rst[t]  <= 1'b0;
        src_q[t]    <= '0;
        frr_q[t]    <= 1'b0;
        ie_q[t]     <= 1'b0;
        sps_q[t]    <= '0;
        psr_q[t]    <= '0;
        ref_q[t]    <= '0;
      end else begin
        if (bus_we && cfg_sel) begin
          tmr_stop[t] <= bus_wdata[SP];
          tmr_rst[t]  <= bus_wdata[RP];
        end
        if (mode_we[t]) begin
          src_q[t] <= bus_wdata[MODE_SRC_LSB +: 2];
          frr_q[t] <= bus_wdata[MODE_FRR_BIT];
          ie_q[t]  <= bus_wdata[MODE_IE_BIT];
          sps_q[t] <= bus_wdata[MODE_SPS_LSB +: PS_W];
        end
        if (psr_we[t]) psr_q[t] <= bus_wdata[PS_W-1:0];
        if (ref_we[t]) ref_q[t] <= bus_wdata;
      end
    end

    gtm_ticker #(.PS_W(PS_W), .SLOW_DIV(SLOW_DIV)) i_ticker (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (tmr_rst[t]),
      .stop     (tmr_stop[t]),
      .src      (src_e'(src_q[t])),
      .psr      (psr_q[t]),
      .sps      (sps_q[t]),
      .cnt_tick (cnt_tick[t])
    );

    gtm_count #(.CNT_W(CNT_W)) i_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tmr_rst[t]),
      .tick    (cnt_tick[t]),
      .restart (frr_q[t]),
      .ref_val (ref_q[t]),
      .we      (cnt_we[t]),
      .wdata   (bus_wdata),
      .cnt     (cnt_q[t]),
      .hit     (ref_hit[t])
    );

    gtm_evt i_evt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_rst[t]),
      .set   (ref_hit[t]),
      .ack   (evt_we[t] && bus_wdata[EVT_REF_BIT]),
      .flag  (evt_flag[t])
    );

    assign irq[t] = evt_flag[t] && ie_q[t];
  end

  always_comb begin
    bus_rdata = '0;
    if (cfg_sel) begin
      for (int t = 0; t < NT; t++) begin
        bus_rdata[stop_pos(t)] = tmr_stop[t];
        bus_rdata[rst_pos(t)]  = tmr_rst[t];
      end
    end
    for (int t = 0; t < NT; t++) begin
      if (sel[t]) begin
        case (ofs)
          OFS_MODE: begin
            bus_rdata[MODE_SRC_LSB +: 2]    = src_q[t];
            bus_rdata[MODE_FRR_BIT]         = frr_q[t];
            bus_rdata[MODE_IE_BIT]          = ie_q[t];
            bus_rdata[MODE_SPS_LSB +: PS_W] = sps_q[t];
          end
          OFS_PSR: bus_rdata[PS_W-1:0]     = psr_q[t];
          OFS_CNT: bus_rdata               = cnt_q[t];
          OFS_REF: bus_rdata               = ref_q[t];
          OFS_EVT: bus_rdata[EVT_REF_BIT]  = evt_flag[t];
          default: bus_rdata               = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/gtm_pair_chk.sv
module gtm_pair_chk #(
  parameter int CNT_W = 16,
  parameter int NT    = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NT-1:0]            tmr_stop,
  input logic [NT-1:0]            tmr_rst,
  input logic [NT-1:0][1:0]       src_q,
  input logic [NT-1:0]            frr_q,
  input logic [NT-1:0][CNT_W-1:0] ref_q,
  input logic [NT-1:0][CNT_W-1:0] cnt_q,
  input logic [NT-1:0]            cnt_tick,
  input logic [NT-1:0]            ref_hit,
  input logic [NT-1:0]            evt_flag,
  input logic [NT-1:0]            cnt_we,
  input logic [1:0]               irq
);
  for (genvar t = 0; t < NT; t++) begin : g_chk
    AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_rst[t] |=> (cnt_q[t] == '0) && !evt_flag[t]); // R9

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_stop[t] && !tmr_rst[t] && !cnt_we[t]) |=> (cnt_q[t] == $past(cnt_q[t]))); // R10

    AST_HIT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_hit[t] && !tmr_rst[t]) |=> evt_flag[t]); // R6

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_tick[t] && frr_q[t] && (cnt_q[t] == ref_q[t]) && !cnt_we[t] && !tmr_rst[t])
      |=> (cnt_q[t] == '0)); // R4

    AST_FREE_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_tick[t] && !frr_q[t] && !cnt_we[t] && !tmr_rst[t])
      |=> (cnt_q[t] == CNT_W'($past(cnt_q[t]) + 1'b1))); // R5

    AST_NO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_q[t] == 2'd0) || (src_q[t] == 2'd3)) |-> !cnt_tick[t]); // R2

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_flag[t] |-> !irq[t]); // R6
  end
endmodule

bind gtm_pair gtm_pair_chk #(.CNT_W(CNT_W), .NT(2)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tmr_stop (tmr_stop),
  .tmr_rst  (tmr_rst),
  .src_q    (src_q),
  .frr_q    (frr_q),
  .ref_q    (ref_q),
  .cnt_q    (cnt_q),
  .cnt_tick (cnt_tick),
  .ref_hit  (ref_hit),
  .evt_flag (evt_flag),
  .cnt_we   (cnt_we),
  .irq      (irq)
);

// File: tb/test_gtm_pair.sv
module test_gtm_pair;
  localparam int PERIOD = 10;
  localparam int QTR    = PERIOD / 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  gtm_pair i_gtm_pair (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  // ---------------- behavioural model ----------------
  int m_stop[2], m_rst[2], m_src[2], m_frr[2], m_ie[2];
  int m_sps[2], m_psr[2], m_cnt[2], m_ref[2], m_evt[2];
  int m_slow[2], m_acc[2];

  always @(posedge clk) begin
    int a, g, o;
    a = int'(bus_addr);
    g = a / 8;
    o = a % 8;
    if (!rst_n) begin
      for (int t = 0; t < 2; t++) begin
        m_stop[t] = 0; m_rst[t] = 0; m_src[t] = 0; m_frr[t] = 0; m_ie[t] = 0;
        m_sps[t] = 0; m_psr[t] = 0; m_cnt[t] = 0; m_ref[t] = 0; m_evt[t] = 0;
        m_slow[t] = 0; m_acc[t] = 0;
      end
    end else begin
      for (int t = 0; t < 2; t++) begin
        int hit, st;
        hit = 0;
        if (m_rst[t] != 0) begin
          m_cnt[t] = 0; m_acc[t] = 0; m_slow[t] = 0; m_evt[t] = 0;
        end else begin
          if (m_stop[t] == 0) begin
            st = ((m_src[t] == 1) || (m_src[t] == 2 && m_slow[t] == 15)) ? 1 : 0;
            m_slow[t] = (m_slow[t] + 1) % 16;
            if (st != 0) begin
              if (m_acc[t] >= (m_psr[t] + 1) * (m_sps[t] + 1) - 1) begin
                m_acc[t] = 0;
                if (m_cnt[t] == m_ref[t]) hit = 1;
                m_cnt[t] = (hit != 0 && m_frr[t] != 0) ? 0 : (m_cnt[t] + 1) % 65536;
              end else begin
                m_acc[t] = m_acc[t] + 1;
              end
            end
          end
          if (bus_we && g == t + 1 && o == 2) m_cnt[t] = int'(bus_wdata);
          if (bus_we && g == t + 1 && o == 4 && bus_wdata[1]) m_evt[t] = 0;
          if (hit != 0) m_evt[t] = 1;
        end
      end
      if (bus_we) begin
        if (a == 0) begin
          m_stop[0] = bus_wdata[1]; m_rst[0] = bus_wdata[0];
          m_stop[1] = bus_wdata[5]; m_rst[1] = bus_wdata[4];
        end
        for (int t = 0; t < 2; t++) begin
          if (g == t + 1 && o == 0) begin
            m_src[t] = int'(bus_wdata[2:1]); m_frr[t] = bus_wdata[3];
            m_ie[t] = bus_wdata[4]; m_sps[t] = int'(bus_wdata[15:8]);
          end
          if (g == t + 1 && o == 1) m_psr[t] = int'(bus_wdata[7:0]);
          if (g == t + 1 && o == 3) m_ref[t] = int'(bus_wdata);
        end
      end
    end
  end

  function automatic int m_read(input int a);
    int g, o, t;
    g = a / 8;
    o = a % 8;
    if (a == 0) return m_stop[1]*32 + m_rst[1]*16 + m_stop[0]*2 + m_rst[0];
    if (g < 1 || g > 2) return 0;
    t = g - 1;
    case (o)
      0: return m_sps[t]*256 + m_ie[t]*16 + m_frr[t]*8 + m_src[t]*2;
      1: return m_psr[t];
      2: return m_cnt[t];
      3: return m_ref[t];
      4: return m_evt[t]*2;
      default: return 0;
    endcase
  endfunction

  // ---------------- checking ----------------
  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      if (bad < 20) $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #(QTR);
    if (rst_n && !done) begin
      chk("R6 model irq0", int'(irq[0]), m_evt[0] * m_ie[0]);
      chk("R6 model irq1", int'(irq[1]), m_evt[1] * m_ie[1]);
      if (!bus_we) chk("R1 model rdata", int'(bus_rdata), m_read(int'(bus_addr)));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    bus_addr = 5'(a);
    #1 v = int'(bus_rdata);
  endtask

  task automatic wait_irq(input int t, output int n);
    n = 0;
    for (int k = 0; k < 400; k++) begin
      @(posedge clk);
      n++;
      #(QTR);
      if (irq[t]) break;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  localparam int T0 = 8;
  localparam int T1 = 16;

  initial begin
    int v, c1, c2, n, prev;
    bit wrapped;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 24; a++) begin
      rd(a, v);
      chk("R1 reset value", v, 0);
    end
    chk("R6 irq after reset", int'(irq), 0);

    // R1: reserved bits
    wr(0, 16'hFFFF);   rd(0, v);        chk("R1 cfg reserved", v, 16'h0033);
    wr(T0, 16'hFFFF);  rd(T0, v);       chk("R1 mode reserved", v, 16'hFF1E);
    wr(T0+1, 16'hFFFF); rd(T0+1, v);    chk("R1 psr reserved", v, 16'h00FF);
    wr(T0+4, 16'hFFFF); rd(T0+4, v);    chk("R1 evt reads zero", v, 0);

    // Bring-up timer 0: internal clock, psr 1, sps 2, restart, irq on, ref 3
    wr(0, 16'h0033);
    wr(0, 16'h0032);
    wr(T0+1, 1);
    wr(T0, 16'h021A);
    wr(T0+2, 0);
    wr(T0+3, 3);
    wr(T0+4, 16'hFFFF);
    wr(0, 16'h0030);
    wait_irq(0, n);
    chk("R3 R6 irq latency 6*4", n, 24);
    rd(T0+2, v); chk("R4 restart to zero", v, 0);
    rd(T0+4, v); chk("R6 event bit1", v, 2);

    // R7: write-one-to-clear
    wr(T0+4, 16'h0000); rd(T0+4, v); chk("R7 zero write keeps", v, 2);
    wr(T0+4, 16'hFFFF); rd(T0+4, v); chk("R7 one write clears", v, 0);
    chk("R7 irq cleared", int'(irq[0]), 0);

    // R10: stop holds, writes land while stopped
    wr(0, 16'h0032);
    rd(T0+2, c1);
    repeat (20) @(negedge clk);
    rd(T0+2, c2);
    chk("R10 stop holds counter", c2, c1);
    wr(T0+2, 5); rd(T0+2, v); chk("R10 counter write while stopped", v, 5);

    // R5: free run across wrap, ref 1
    wr(T0, 16'h0212);
    wr(T0+2, 16'hFFFD);
    wr(T0+3, 1);
    wr(T0+4, 16'hFFFF);
    wr(0, 16'h0030);
    prev = 16'hFFFD; wrapped = 0;
    for (int k = 0; k < 300; k++) begin
      rd(T0+2, v);
      if (!wrapped && prev == 16'hFFFF && v == 0) begin
        wrapped = 1;
        chk("R5 no event at wrap", int'(irq[0]), 0);
      end
      if (irq[0]) begin
        chk("R5 R6 count continues past match", v, 2);
        break;
      end
      prev = v;
    end
    chk("R5 wrap seen", int'(wrapped), 1);

    // R2 R3 R8: timer 1 slow mode, psr 1, ref 1, restart
    wr(0, 16'h0022);
    wr(T1, 16'h001C);
    wr(T1+1, 1);
    wr(T1+3, 1);
    wr(T1+2, 0);
    wr(T1+4, 16'hFFFF);
    rd(T0+2, c1);
    wr(0, 16'h0002);
    wait_irq(1, n);
    chk("R2 R3 slow latency 16*2*2", n, 64);
    rd(T1+2, v); chk("R4 timer1 restart", v, 0);
    rd(T0+2, v); chk("R8 timer0 still stopped", v, c1);

    // R2: source 0 does not count
    wr(0, 16'h0022);
    wr(T1, 16'h0018);
    wr(T1+2, 16'h0040);
    wr(0, 16'h0002);
    repeat (100) @(negedge clk);
    rd(T1+2, v); chk("R2 source 0 holds", v, 16'h0040);

    // R9: reset clears and blocks writes
    wr(0, 16'h0012);
    rd(T1+2, v); chk("R9 reset clears counter", v, 0);
    rd(T1+4, v); chk("R9 reset clears event", v, 0);
    chk("R9 irq1 low in reset", int'(irq[1]), 0);
    wr(T1+2, 16'h1234); rd(T1+2, v); chk("R9 write ignored in reset", v, 0);

    // R8: timer1 stop bit 5 leaves timer0 running
    wr(0, 16'h0020);
    rd(T0+2, c1);
    repeat (30) @(negedge clk);
    rd(T0+2, c2);
    chk("R8 timer0 runs under bit5", int'(c2 != c1), 1);
    rd(0, v); chk("R8 cfg readback", v, 16'h0020);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule